// File: doc/BRIEF.md
# Video Blanking Timing Generator

This block counts clock cycles to produce the display timing that the rest of the chip's timers and interrupt logic follow. A horizontal machine alternates between a render phase and a blank phase of the programmed lengths. A vertical machine steps through three states: render, a short window after vblank start that ends in a field swap, and the rest of the vertical blank. Each boundary produces a one-cycle event pulse. Timer channels use these pulses as gate-start and gate-end strobes.

The block computes none of the period constants. Software or a configuration block supplies the phase lengths in cycles: horizontal render, horizontal blank, vertical render, swap delay (3.5 scanlines) and vertical blank. It also supplies the horizontal drift value, which is the vertical period minus the summed horizontal periods and is zero for progressive modes. At every vblank start, the current horizontal phase is stretched by the drift value so that the horizontal schedule does not walk away from the vertical one. Two sticky status bits, one for hsync and one for vsync, each have a mask input and a write-1-to-clear port. An interrupt pulse is raised only when a status bit goes from clear to set while its mask is low.

Top module: `vblank_timing_gen`

## Requirements
- R1: After reset the horizontal output `hblank` is low for `hrender_len` cycles and then high for `hblank_len` cycles, and it keeps alternating. `hbl_start` pulses in the first cycle of each blank phase and `hbl_end` pulses in the first cycle of each render phase.
- R2: While reset is asserted, every output is 0 and `frame_cnt` is 0.
- R3: `vblank` rises `vrender_len` cycles after it last fell, or after reset. `vbl_start` pulses in the first cycle of `vblank` high.
- R4: `vswap_len` cycles after vblank start, `field_swap` pulses and `field` toggles in the same cycle. `field` changes at no other time.
- R5: `vblank` falls `vblank_len` cycles after vblank start. This time is counted from vblank start, not from the field swap. `vbl_end` pulses in the first cycle of `vblank` low, and `frame_cnt` increments in that same cycle.
- R6: `hsint` is set in the cycle that `hbl_end` pulses. `irq_hs` pulses in that cycle only if `hsint` was clear and `hs_mask` was 0.
- R7: `vsint` is set in the cycle that `field_swap` pulses. `irq_vs` pulses in that cycle only if `vsint` was clear and `vs_mask` was 0.
- R8: A cycle with `clr_we` high clears `hsint` when `clr_bits[0]` is 1 and clears `vsint` when `clr_bits[1]` is 1. A bit written as 0 leaves its status bit unchanged.
- R9: The horizontal phase in progress at a vblank start lasts `hdrift` extra cycles. A phase that begins in the same cycle as vblank start counts as in progress.
- R10: The mask inputs gate only the interrupt pulses. `hsint` and `vsint` are still set while masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hrender_len | input | CW | Horizontal render phase length in cycles |
| hblank_len | input | CW | Horizontal blank phase length in cycles |
| vrender_len | input | CW | Vertical render length in cycles |
| vswap_len | input | CW | Delay from vblank start to field swap |
| vblank_len | input | CW | Vertical blank length from vblank start |
| hdrift | input | CW | Cycles added to the horizontal phase at vblank start |
| hs_mask | input | 1 | Masks the hsync interrupt pulse |
| vs_mask | input | 1 | Masks the vsync interrupt pulse |
| clr_we | input | 1 | Status clear strobe |
| clr_bits | input | 2 | Bit 0 clears hsint, bit 1 clears vsint |
| hblank | output | 1 | Horizontal blank phase |
| vblank | output | 1 | Vertical blank (swap window plus blank) |
| field | output | 1 | Field indicator |
| hsint | output | 1 | Sticky hsync status |
| vsint | output | 1 | Sticky vsync status |
| hbl_start | output | 1 | Pulse: horizontal blank begins (gate start) |
| hbl_end | output | 1 | Pulse: horizontal blank ends (gate end) |
| vbl_start | output | 1 | Pulse: vertical blank begins (gate start) |
| vbl_end | output | 1 | Pulse: vertical blank ends (gate end) |
| field_swap | output | 1 | Pulse: field swap |
| irq_hs | output | 1 | Hsync interrupt request pulse |
| irq_vs | output | 1 | Vsync interrupt request pulse |
| frame_cnt | output | FW | Count of completed vertical blanks |

## Verification
The scheduling is tested with unequal render and blank lengths and with a nonzero drift. In the chosen setup, a vblank start falls in the middle of a horizontal render phase. The expected time of every edge is predicted from the requirements alone. The two vertical blanks separate the drift stretch from ordinary phase alternation, and they show that vblank end is timed from vblank start rather than from the swap. A second stage tests the status bits. It clears the bits selectively, then lets a status bit set while its mask is high, and then while the bit is already set. These cases show which condition suppressed each interrupt pulse.

// File: rtl/vblank_timing_gen.sv
module vblank_timing_gen #(
  parameter int CW = 16,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] hrender_len,
  input  logic [CW-1:0] hblank_len,
  input  logic [CW-1:0] vrender_len,
  input  logic [CW-1:0] vswap_len,
  input  logic [CW-1:0] vblank_len,
  input  logic [CW-1:0] hdrift,
  input  logic          hs_mask,
  input  logic          vs_mask,
  input  logic          clr_we,
  input  logic [1:0]    clr_bits,
  output logic          hblank,
  output logic          vblank,
  output logic          field,
  output logic          hsint,
  output logic          vsint,
  output logic          hbl_start,
  output logic          hbl_end,
  output logic          vbl_start,
  output logic          vbl_end,
  output logic          field_swap,
  output logic          irq_hs,
  output logic          irq_vs,
  output logic [FW-1:0] frame_cnt
);
  typedef enum logic [1:0] {V_REN, V_SWAP, V_BLK} vst_t;

  vst_t          vst;
  logic [CW:0]   hcnt, vcnt, hext;
  logic [CW:0]   h_lim, v_lim;
  logic          h_done, v_done, ren_done, swp_done, blk_done, hs_set;

  assign h_lim    = {1'b0, hblank ? hblank_len : hrender_len} + hext;
  assign h_done   = (hcnt + 1'b1) >= h_lim;
  assign v_lim    = {1'b0, (vst == V_REN) ? vrender_len : (vst == V_SWAP) ? vswap_len : vblank_len};
  assign v_done   = (vcnt + 1'b1) >= v_lim;
  assign ren_done = (vst == V_REN)  && v_done;
  assign swp_done = (vst == V_SWAP) && v_done;
  assign blk_done = (vst == V_BLK)  && v_done;
  assign hs_set   = hblank && h_done;
  assign vblank   = (vst != V_REN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hblank <= 1'b0;
      hcnt   <= '0;
      hext   <= '0;
    end else begin
      hcnt <= h_done ? '0 : hcnt + 1'b1;
      if (h_done) hblank <= ~hblank;
      if (ren_done)    hext <= {1'b0, hdrift};
      else if (h_done) hext <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vst       <= V_REN;
      vcnt      <= '0;
      field     <= 1'b0;
      frame_cnt <= '0;
    end else begin
      vcnt <= (ren_done || blk_done) ? '0 : vcnt + 1'b1;
      if (ren_done) vst <= V_SWAP;
      if (swp_done) begin
        vst   <= V_BLK;
        field <= ~field;
      end
      if (blk_done) begin
        vst       <= V_REN;
        frame_cnt <= frame_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hbl_start  <= 1'b0;
      hbl_end    <= 1'b0;
      vbl_start  <= 1'b0;
      vbl_end    <= 1'b0;
      field_swap <= 1'b0;
      hsint      <= 1'b0;
      vsint      <= 1'b0;
      irq_hs     <= 1'b0;
      irq_vs     <= 1'b0;
    end else begin
      hbl_start  <= !hblank && h_done;
      hbl_end    <= hs_set;
      vbl_start  <= ren_done;
      vbl_end    <= blk_done;
      field_swap <= swp_done;
      hsint      <= hs_set   | (hsint & ~(clr_we & clr_bits[0]));
      vsint      <= swp_done | (vsint & ~(clr_we & clr_bits[1]));
      irq_hs     <= hs_set   & ~hsint & ~hs_mask;
      irq_vs     <= swp_done & ~vsint & ~vs_mask;
    end
  end
endmodule

// File: rtl/vblank_timing_gen_chk.sv
module vblank_timing_gen_chk #(
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hs_mask,
  input logic          vs_mask,
  input logic          clr_we,
  input logic [1:0]    clr_bits,
  input logic          hblank,
  input logic          vblank,
  input logic          field,
  input logic          hsint,
  input logic          vsint,
  input logic          hbl_start,
  input logic          hbl_end,
  input logic          vbl_start,
  input logic          vbl_end,
  input logic          field_swap,
  input logic          irq_hs,
  input logic          irq_vs,
  input logic [FW-1:0] frame_cnt
);
  AST_HBL_START_PHASE: assert property (@(posedge clk) disable iff (!rst_n) hbl_start |-> hblank && !$past(hblank)); // R1
  AST_HBL_END_PHASE:   assert property (@(posedge clk) disable iff (!rst_n) hbl_end |-> !hblank && $past(hblank)); // R1
  AST_VBL_ENTRY:       assert property (@(posedge clk) disable iff (!rst_n) $rose(vblank) |-> vbl_start); // R3
  AST_VBL_EXIT:        assert property (@(posedge clk) disable iff (!rst_n) vbl_end |-> !vblank && $past(vblank)); // R5
  AST_VEVT_EXCL:       assert property (@(posedge clk) disable iff (!rst_n) $onehot0({vbl_start, vbl_end})); // R3
  AST_FIELD_TOGGLE:    assert property (@(posedge clk) disable iff (!rst_n) field_swap |-> field != $past(field)); // R4
  AST_FIELD_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !field_swap |-> $stable(field)); // R4
  AST_FRAME_STEP:      assert property (@(posedge clk) disable iff (!rst_n) vbl_end |-> frame_cnt == $past(frame_cnt) + 1'b1); // R5
  AST_HS_IRQ_GATE:     assert property (@(posedge clk) disable iff (!rst_n) irq_hs |-> hbl_end && !$past(hsint) && !$past(hs_mask)); // R6
  AST_VS_IRQ_GATE:     assert property (@(posedge clk) disable iff (!rst_n) irq_vs |-> field_swap && !$past(vsint) && !$past(vs_mask)); // R7
  AST_HS_CLEAR:        assert property (@(posedge clk) disable iff (!rst_n) $past(clr_we && clr_bits[0]) && !hbl_end |-> !hsint); // R8
  AST_VS_CLEAR:        assert property (@(posedge clk) disable iff (!rst_n) $past(clr_we && clr_bits[1]) && !field_swap |-> !vsint); // R8
  AST_HS_SET_MASKED:   assert property (@(posedge clk) disable iff (!rst_n) hbl_end |-> hsint); // R10
  AST_VS_SET_MASKED:   assert property (@(posedge clk) disable iff (!rst_n) field_swap |-> vsint); // R10
endmodule

bind vblank_timing_gen vblank_timing_gen_chk #(.FW(FW)) chk_i (.*);

// File: tb/vblank_timing_gen_tb_top.sv
module vblank_timing_gen_tb_top;
  localparam int CW = 16, FW = 16;
  localparam int HR = 5, HB = 4, VR = 40, VS = 7, VB = 20, DR = 3, TEND = 160;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, hs_mask, vs_mask, clr_we;
  logic [1:0] clr_bits;
  logic hblank, vblank, field, hsint, vsint, hbl_start, hbl_end, vbl_start, vbl_end;
  logic field_swap, irq_hs, irq_vs;
  logic [FW-1:0] frame_cnt;

  vblank_timing_gen #(.CW(CW), .FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .hrender_len(CW'(HR)), .hblank_len(CW'(HB)), .vrender_len(CW'(VR)),
    .vswap_len(CW'(VS)), .vblank_len(CW'(VB)), .hdrift(CW'(DR)),
    .hs_mask(hs_mask), .vs_mask(vs_mask), .clr_we(clr_we), .clr_bits(clr_bits),
    .hblank(hblank), .vblank(vblank), .field(field), .hsint(hsint), .vsint(vsint),
    .hbl_start(hbl_start), .hbl_end(hbl_end), .vbl_start(vbl_start), .vbl_end(vbl_end),
    .field_swap(field_swap), .irq_hs(irq_hs), .irq_vs(irq_vs), .frame_cnt(frame_cnt)
  );

  int cyc;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  int q_hs[$], q_he[$], q_vs[$], q_sw[$], q_ve[$], q_ih[$], q_iv[$];
  int checks = 0, fails = 0, n_ve = 0, n_sw = 0;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic pop_chk(input string rq, input string nm, ref int q[$]);
    if (q.size() == 0) chk(1'b0, rq, {nm, " unexpected at cycle"}, cyc, -1);
    else begin
      int e = q.pop_front();
      chk(e == cyc, rq, {nm, " cycle"}, cyc, e);
    end
  endtask

  task automatic build_sched();
    int vst[$];
    int t = VR;
    int s = 0;
    bit ph = 1'b0;
    while (t <= TEND) begin
      vst.push_back(t);
      q_vs.push_back(t);
      if (t + VS <= TEND) q_sw.push_back(t + VS);
      if (t + VB <= TEND) q_ve.push_back(t + VB);
      t += VR + VB;
    end
    q_ih.push_back(HR + HB);
    q_iv.push_back(VR + VS);
    while (s < TEND) begin
      int len = ph ? HB : HR;
      int e = s + len;
      foreach (vst[i]) if (vst[i] >= s && vst[i] < s + len) e += DR; // R9 stretch
      if (e <= TEND) begin
        if (ph) q_he.push_back(e);
        else    q_hs.push_back(e);
      end
      s = e;
      ph = ~ph;
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && cyc <= TEND) begin
      if (hbl_start)  pop_chk("R1", "hblank start (R9 drift)", q_hs);
      if (hbl_end)    pop_chk("R1", "hblank end", q_he);
      if (vbl_start)  pop_chk("R3", "vblank start", q_vs);
      if (field_swap) begin
        pop_chk("R4", "field swap", q_sw);
        n_sw++;
        chk(field == n_sw[0], "R4", "field value", field, n_sw[0]);
        chk(vsint == 1'b1, "R7", "vsint at swap", vsint, 1);
      end
      if (vbl_end) begin
        pop_chk("R5", "vblank end", q_ve);
        n_ve++;
        chk(frame_cnt == FW'(n_ve), "R5", "frame count", frame_cnt, n_ve);
      end
      if (irq_hs) pop_chk("R6", "hsync irq", q_ih);
      if (irq_vs) pop_chk("R7", "vsync irq", q_iv);
    end
  end

  task automatic run_main();
    rst_n = 1'b0; hs_mask = 1'b0; vs_mask = 1'b0; clr_we = 1'b0; clr_bits = 2'b00;
    build_sched();
    repeat (3) @(negedge clk);
    chk({hblank, vblank, field, hsint, vsint, hbl_start, hbl_end, vbl_start, vbl_end,
         field_swap, irq_hs, irq_vs} == 12'b0, "R2", "outputs in reset", hblank | vblank | hsint, 0);
    chk(frame_cnt == '0, "R2", "frame count in reset", frame_cnt, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    while (cyc < TEND + 1) @(negedge clk);
    chk(q_hs.size() == 0, "R9", "missing hblank starts", q_hs.size(), 0);
    chk(q_he.size() == 0, "R1", "missing hblank ends", q_he.size(), 0);
    chk(q_vs.size() + q_sw.size() == 0, "R4", "missing vertical events", q_vs.size() + q_sw.size(), 0);
    chk(q_ve.size() == 0, "R5", "missing vblank ends", q_ve.size(), 0);
    chk(q_ih.size() + q_iv.size() == 0, "R6", "missing irqs", q_ih.size() + q_iv.size(), 0);

    do @(negedge clk); while (!hbl_start);
    clr_we = 1'b1; clr_bits = 2'b01;
    @(negedge clk);
    clr_we = 1'b0; clr_bits = 2'b00;
    chk(hsint == 1'b0, "R8", "hsint after clear", hsint, 0);
    chk(vsint == 1'b1, "R8", "vsint untouched", vsint, 1);

    hs_mask = 1'b1;
    do @(negedge clk); while (!hbl_end);
    chk(hsint == 1'b1, "R10", "hsint set while masked", hsint, 1);
    chk(irq_hs == 1'b0, "R6", "irq_hs while masked", irq_hs, 0);
    hs_mask = 1'b0;
    do @(negedge clk); while (!hbl_end);
    chk(irq_hs == 1'b0, "R6", "irq_hs while already set", irq_hs, 0);

    do @(negedge clk); while (!vbl_end);
    clr_we = 1'b1; clr_bits = 2'b10;
    @(negedge clk);
    clr_we = 1'b0; clr_bits = 2'b00;
    chk(vsint == 1'b0, "R8", "vsint after clear", vsint, 0);
    chk(hsint == 1'b1, "R8", "hsint untouched", hsint, 1);
    vs_mask = 1'b1;
    do @(negedge clk); while (!field_swap);
    chk(vsint == 1'b1, "R10", "vsint set while masked", vsint, 1);
    chk(irq_vs == 1'b0, "R7", "irq_vs while masked", irq_vs, 0);
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, TEND);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule